// File: doc/BRIEF.md
# Dual-Input Capture/Compare Timer

This block holds a 16-bit free-running up-counter that advances once per count-clock period and two 16-bit slots beside it. Each slot works either as a capture register, loading the counter value when a trigger arrives, or as a compare register that raises an interrupt when the counter reaches it. Two external trigger lines pass through a synchronizer and a noise filter. An edge selector then picks which of their transitions count as valid. A cross-select bit decides whether slot 0 follows trigger line 1 (as slot 1 always does) or the opposite transition of trigger line 0.

The count clock is given to the block as two strobes in the system clock domain. `cc_rise` marks its rising phase and `cc_fall` marks its falling phase. Trigger lines are sampled only on rising phases. A capture is latched on the falling phase that follows a valid edge, and the slot's interrupt is a one-cycle pulse after the next rising phase. Software programs the slots and the configuration through simple write strobes, and reads a slot through a registered read port.

Top module: `cc_timer`

## Requirements
- R1: The counter resets to 0 and increments by one on each `cc_rise`. It wraps from 0xFFFF to 0x0000 and holds between strobes.
- R2: An active-high synchronous reset clears the counter, both slots, the read data, the configuration and both interrupt outputs.
- R3: Configuration is loaded from `cfg_data` on `cfg_we`, with this layout:
  - bit 0 puts slot 0 in compare mode.
  - bit 1 puts slot 1 in compare mode.
  - bits 3:2 select the valid edges of trigger 0 (bit 2 enables rising, bit 3 enables falling).
  - bits 5:4 select the valid edges of trigger 1 in the same way.
  - bit 6 is the cross-select.
  
  With both enable bits of a line clear, that line produces no valid edge.
- R4: A trigger level is accepted only after it has been seen on three consecutive `cc_rise` samples (after the synchronizer). A pulse lasting two count periods causes no capture and no interrupt.
- R5: A valid edge is recognised on the `cc_rise` of its third stable sample. On the next `cc_fall`, the counter value (which equals that sample's rise count) is latched. The interrupt of the slot is a one-cycle pulse after the following `cc_rise`.
- R6: A slot in compare mode never loads the counter on a trigger.
- R7: A slot in compare mode pulses its interrupt once when the counter equals the slot value on a `cc_rise` cycle.
- R8: With cross-select set, slot 0 captures on the opposite transition of trigger 0: falling when rising is enabled, rising when falling is enabled. With both edges enabled, slot 0 never captures.
- R9: With cross-select set, a valid edge of trigger 1 does not load slot 0 but still pulses `irq0`.
- R10: With cross-select clear, a valid edge of trigger 1 captures into slot 0 and slot 1 together and pulses both interrupts.
- R11: `rd_data` loads the slot chosen by `rd_sel` (0 = slot 0, 1 = slot 1) one cycle after `rd_en` and holds otherwise. A read in the latch cycle returns the prior value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cc_rise | input | 1 | Count-clock rising-phase strobe |
| cc_fall | input | 1 | Count-clock falling-phase strobe |
| trig0 | input | 1 | External trigger line 0 (asynchronous) |
| trig1 | input | 1 | External trigger line 1 (asynchronous) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 7 | Configuration value (layout in R3) |
| wr_en | input | 1 | Slot write strobe |
| wr_sel | input | 1 | Slot written: 0 or 1 |
| wr_data | input | 16 | Slot write value |
| rd_en | input | 1 | Slot read strobe |
| rd_sel | input | 1 | Slot read: 0 or 1 |
| rd_data | output | 16 | Registered read data |
| irq0 | output | 1 | Slot 0 interrupt pulse |
| irq1 | output | 1 | Slot 1 interrupt pulse |

## Verification
The properties rely on these assumptions:
- `cc_rise` and `cc_fall` never fall in the same cycle.
- `cc_rise` is never high on two consecutive cycles, so an interrupt pulse can never be stretched.
- Both trigger lines are low while reset is held.

The stimulus generator meets these assumptions in two ways. In its slow pattern, `cc_fall` comes two cycles after each `cc_rise` and the period is four cycles. In its fast pattern, used only to run the counter through its wrap, the two strobes simply alternate. Trigger transitions are applied just after a rising phase, which leaves the synchronizer settled before the next sample.

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int W    = 16,
  parameter int SYNC = 2,
  parameter int FILT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cc_rise,
  input  logic         cc_fall,
  input  logic         trig0,
  input  logic         trig1,
  input  logic         cfg_we,
  input  logic [6:0]   cfg_data,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic         irq0,
  output logic         irq1
);

  logic [W-1:0] cnt, slot0, slot1;
  logic [1:0]   cmp, esel0, esel1;
  logic         xsel;
  logic [1:0]   tin, rise_ev, fall_ev;
  logic [1:0]   pcap, arm, want_cap, match;
  logic         pint0, want_int0, valid1, opp0;

  assign tin = {trig1, trig0};

  for (genvar i = 0; i < 2; i++) begin : g_in
    logic [SYNC-1:0] sy;
    logic [FILT-1:0] hist, nh;
    logic            lvl, steady;

    assign nh         = {hist[FILT-2:0], sy[SYNC-1]};
    assign steady     = (&nh) | ~(|nh);
    assign rise_ev[i] = cc_rise & steady & nh[0] & ~lvl;
    assign fall_ev[i] = cc_rise & steady & ~nh[0] & lvl;

    always_ff @(posedge clk) begin
      if (rst) begin
        sy   <= '0;
        hist <= '0;
        lvl  <= 1'b0;
      end else begin
        sy <= {sy[SYNC-2:0], tin[i]};
        if (cc_rise) begin
          hist <= nh;
          if (steady) lvl <= nh[0];
        end
      end
    end
  end

  assign valid1      = (esel1[0] & rise_ev[1]) | (esel1[1] & fall_ev[1]);
  assign opp0        = ~(esel0[0] & esel0[1]) &
                       ((esel0[0] & fall_ev[0]) | (esel0[1] & rise_ev[0]));
  assign want_cap[0] = ~cmp[0] & (xsel ? opp0 : valid1);
  assign want_cap[1] = ~cmp[1] & valid1;
  assign want_int0   = ~cmp[0] & xsel & valid1;
  assign match[0]    = cmp[0] & (cnt == slot0);
  assign match[1]    = cmp[1] & (cnt == slot1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      slot0   <= '0;
      slot1   <= '0;
      pcap    <= '0;
      pint0   <= 1'b0;
      arm     <= '0;
      irq0    <= 1'b0;
      irq1    <= 1'b0;
      rd_data <= '0;
      cmp     <= '0;
      esel0   <= '0;
      esel1   <= '0;
      xsel    <= 1'b0;
    end else begin
      irq0 <= cc_rise & (arm[0] | match[0]);
      irq1 <= cc_rise & (arm[1] | match[1]);
      if (cc_rise) begin
        cnt   <= cnt + W'(1);
        arm   <= '0;
        pcap  <= pcap | want_cap;
        pint0 <= pint0 | want_int0;
      end
      if (cc_fall) begin
        if (pcap[0] & ~cmp[0]) slot0 <= cnt;
        if (pcap[1] & ~cmp[1]) slot1 <= cnt;
        arm   <= arm | (pcap & ~cmp) | {1'b0, pint0};
        pcap  <= '0;
        pint0 <= 1'b0;
      end
      if (cfg_we) {xsel, esel1, esel0, cmp} <= cfg_data;
      if (wr_en) begin
        if (wr_sel) slot1 <= wr_data;
        else        slot0 <= wr_data;
      end
      if (rd_en) rd_data <= rd_sel ? slot1 : slot0;
    end
  end

endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cc_rise,
  input logic         cc_fall,
  input logic         wr_en,
  input logic         cmp1,
  input logic         irq0,
  input logic         irq1,
  input logic [W-1:0] cnt,
  input logic [W-1:0] slot0,
  input logic [W-1:0] slot1
);

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (cnt == '0 && slot0 == '0 && slot1 == '0 && !irq0 && !irq1)); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    cc_rise |=> cnt == $past(cnt) + W'(1)); // R1

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cc_rise |=> $stable(cnt)); // R1

  AST_LATCH_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !cc_fall) |=> $stable(slot0)); // R5

  AST_CMP_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cmp1 && !wr_en) |=> $stable(slot1)); // R6

  AST_IRQ_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    irq0 |-> $past(cc_rise)); // R5

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq1 |=> !irq1); // R5

endmodule

bind cc_timer cc_timer_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cc_rise(cc_rise),
  .cc_fall(cc_fall),
  .wr_en  (wr_en),
  .cmp1   (cmp[1]),
  .irq0   (irq0),
  .irq1   (irq1),
  .cnt    (cnt),
  .slot0  (slot0),
  .slot1  (slot1)
);

// File: tb/sim_cc_timer.sv
`timescale 1ns/1ps
module sim_cc_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cc_rise = 1'b0, cc_fall = 1'b0;
  logic        trig0 = 1'b0, trig1 = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_data = '0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0, rd_sel = 1'b0;
  logic [15:0] rd_data;
  logic        irq0, irq1;

  int nchk = 0, nfail = 0;
  int nrise = 0, ni0 = 0, ni1 = 0;
  int ph = 3;
  bit run = 0, fast = 0, done = 0;

  cc_timer u0 (
    .clk(clk), .rst(rst), .cc_rise(cc_rise), .cc_fall(cc_fall),
    .trig0(trig0), .trig1(trig1), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq0(irq0), .irq1(irq1)
  );

  always #2.5 clk = ~clk;

  // {ni1[4], ni0[4], exp1[2], exp0[2], width[4], line[1], cfg[7]}
  // exp code: 0 = unchanged, 1 = value at leading edge, 2 = value at trailing edge
  localparam logic [23:0] VEC [11] = '{
    {4'd1, 4'd1, 2'd1, 2'd1, 4'd5, 1'b1, 7'h10},  // R10 R3 rising
    {4'd1, 4'd1, 2'd2, 2'd2, 4'd5, 1'b1, 7'h20},  // R10 R3 falling
    {4'd2, 4'd2, 2'd2, 2'd2, 4'd5, 1'b1, 7'h30},  // R3 both
    {4'd0, 4'd0, 2'd0, 2'd0, 4'd2, 1'b1, 7'h10},  // R4 short pulse
    {4'd0, 4'd0, 2'd0, 2'd0, 4'd5, 1'b1, 7'h00},  // R3 no edge enabled
    {4'd0, 4'd1, 2'd0, 2'd2, 4'd5, 1'b0, 7'h44},  // R8 opposite of rising
    {4'd0, 4'd1, 2'd0, 2'd1, 4'd5, 1'b0, 7'h48},  // R8 opposite of falling
    {4'd0, 4'd0, 2'd0, 2'd0, 4'd5, 1'b0, 7'h4C},  // R8 both selected
    {4'd1, 4'd1, 2'd1, 2'd0, 4'd5, 1'b1, 7'h50},  // R9 interrupt only
    {4'd0, 4'd1, 2'd0, 2'd1, 4'd5, 1'b1, 7'h12},  // R6 slot 1 compare
    {4'd2, 4'd0, 2'd2, 2'd0, 4'd5, 1'b1, 7'h31}   // R6 slot 0 compare
  };
  localparam string TAG [11] = '{"R3 R5 R10", "R3 R5 R10", "R3 R10", "R4", "R3",
                                 "R8", "R8", "R8", "R9", "R6", "R6"};

  initial begin
    wait (run);
    forever begin
      @(negedge clk);
      ph = (ph + 1) % (fast ? 2 : 4);
      cc_rise = (ph == 0);
      cc_fall = (ph == (fast ? 1 : 2));
      if (cc_rise) nrise++;
    end
  end

  initial forever begin
    @(negedge clk);
    if (irq0) ni0++;
    if (irq1) ni1++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_rises(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (cc_rise) k++;
    end
    #1;
  endtask

  task automatic cfg_write(input logic [6:0] v);
    @(posedge clk); #1 cfg_we = 1'b1; cfg_data = v;
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic slot_write(input logic s, input logic [15:0] v);
    @(posedge clk); #1 wr_en = 1'b1; wr_sel = s; wr_data = v;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic slot_read(input logic s, output logic [15:0] v);
    @(posedge clk); #1 rd_en = 1'b1; rd_sel = s;
    @(posedge clk); #1 rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic set_trig(input logic line, input logic lvl);
    if (line) trig1 = lvl;
    else      trig0 = lvl;
  endtask

  function automatic logic [15:0] expv(input logic [1:0] code, input logic [15:0] keep,
                                       input int rup, input int rdn);
    if (code == 2'd1) return 16'((rup + 3) & 32'hFFFF);
    if (code == 2'd2) return 16'((rdn + 3) & 32'hFFFF);
    return keep;
  endfunction

  task automatic run_vec(input logic [23:0] t, input string tag);
    int rup, rdn;
    logic [15:0] v;
    cfg_write(t[6:0]);
    slot_write(1'b0, 16'hA5A5);
    slot_write(1'b1, 16'h5A5A);
    wait_rises(1);
    rup = nrise; ni0 = 0; ni1 = 0;
    set_trig(t[7], 1'b1);
    wait_rises(int'(t[11:8]));
    rdn = nrise;
    set_trig(t[7], 1'b0);
    wait_rises(8);
    slot_read(1'b0, v);
    chk({tag, " slot0"}, 32'(v), 32'(expv(t[13:12], 16'hA5A5, rup, rdn)));
    slot_read(1'b1, v);
    chk({tag, " slot1"}, 32'(v), 32'(expv(t[15:14], 16'h5A5A, rup, rdn)));
    chk({tag, " irq0 count"}, 32'(ni0), 32'(t[19:16]));
    chk({tag, " irq1 count"}, 32'(ni1), 32'(t[23:20]));
  endtask

  initial begin
    #950000;
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] v, held;
    int rup, k;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    // R2: state after reset
    chk("R2 rd_data", 32'(rd_data), 0);
    chk("R2 irq0", 32'(irq0), 0);
    chk("R2 irq1", 32'(irq1), 0);
    slot_read(1'b0, v); chk("R2 slot0", 32'(v), 0);
    slot_read(1'b1, v); chk("R2 slot1", 32'(v), 0);
    run = 1;

    for (int i = 0; i < 11; i++) run_vec(VEC[i], TAG[i]);

    // R7: compare match pulses once
    cfg_write(7'h01);
    wait_rises(1);
    k = nrise + 6;
    slot_write(1'b0, 16'(k & 32'hFFFF));
    ni0 = 0; ni1 = 0;
    wait_rises(14);
    chk("R7 irq0 on match", 32'(ni0), 1);
    chk("R7 irq1 idle", 32'(ni1), 0);

    // R11: rd_data holds without a read strobe, then shows the new capture
    cfg_write(7'h10);
    slot_read(1'b1, held);
    wait_rises(1);
    rup = nrise;
    trig1 = 1'b1; wait_rises(5); trig1 = 1'b0; wait_rises(8);
    chk("R11 rd_data held", 32'(rd_data), 32'(held));
    slot_read(1'b1, v);
    chk("R11 new read", 32'(v), (rup + 3) & 32'hFFFF);

    // R1: counter wraps past 0xFFFF
    fast = 1;
    wait_rises(65536);
    fast = 0;
    wait_rises(2);
    chk("R1 past wrap", 32'(nrise > 65536), 1);
    rup = nrise;
    trig1 = 1'b1; wait_rises(5); trig1 = 1'b0; wait_rises(8);
    slot_read(1'b1, v);
    chk("R1 wrapped capture", 32'(v), (rup + 3) & 32'hFFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule